// File: doc/BRIEF.md
# Synchronous PWM Channel Group

This block generates one pulse-width-modulated output per channel from a free-running counter and a duty threshold. Each channel normally runs on its own timebase, with its own prescaler, period and counting shape. Any subset of channels can be tied into a single synchronous group. Members of the group all follow the timebase of channel 0, so their counters never drift apart and their edges line up. Writes to the other members' own timebase settings then have no effect on their outputs.

Software-style control is through plain strobes. A membership write loads a per-channel mask, but only channels that are disabled at that moment take the new bit. Per-channel enable and disable strobes switch channels on or off. A strobe on channel 0 acts on the whole group at once, while any other member can still be gated on its own. A status vector reports which channels are enabled, and a second vector reports the group membership currently in force.

All interfaces are control and status pins sampled on each clock. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_sync_group`

## Requirements
- R1: Group members whose duty equals channel 0's duty drive exactly the same output as channel 0 on every cycle, including after a member is re-enabled on its own.
- R2: A single group exists. It is held as one membership bit per channel, and `sync_grp` shows the membership in force.
- R3: When any membership bit is set, `sync_grp[0]` reads 1. For example, writing mask 4'b0100 gives `sync_grp` 4'b0101.
- R4: A member other than channel 0 ignores its own prescaler, period and alignment fields and uses channel 0's fields.
- R5: An `en_set[0]` pulse enables channel 0 and every group member on the next cycle. An `en_clr[0]` pulse disables channel 0 and every group member on the next cycle.
- R6: `en_set[i]` and `en_clr[i]` for i>0 switch only channel i on or off, group member or not. When a set and a clear reach the same channel in one cycle, the clear wins.
- R7: On a `sync_wr` pulse, the membership bit of a channel that is enabled keeps its old value. A disabled channel takes the new mask bit.
- R8: Left-aligned mode (center bit 0) counts 0..P and wraps, where P is the period field. The output is high while count < duty, so it is high for min(duty, P+1) of every P+1 ticks.
- R9: Center-aligned mode (center bit 1) counts 0 up to P and back down to 1, giving 2P ticks per period. The output is high for 2*duty-1 ticks when 1<=duty<=P, for 0 ticks when duty=0, and for all ticks when duty>P.
- R10: A prescaler field s (4 bits per channel) makes the counter advance once every 2^s clocks. Values above 10 act as 10.
- R11: A disabled channel drives its output low.
- R12: After reset, `pwm_out`, `en_status` and `sync_grp` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_wr | input | 1 | Membership write strobe |
| sync_mask | input | NCH | Requested membership bits |
| en_set | input | NCH | Per-channel enable strobes |
| en_clr | input | NCH | Per-channel disable strobes |
| cfg_pre | input | NCH*4 | Prescaler select per channel |
| cfg_prd | input | NCH*CW | Period value per channel |
| cfg_center | input | NCH | Alignment per channel, 1 = center |
| cfg_duty | input | NCH*CW | Duty threshold per channel |
| pwm_out | output | NCH | PWM outputs |
| en_status | output | NCH | Enabled channels |
| sync_grp | output | NCH | Membership in force |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and a largest prescaler of 2^10. With four channels, the bench can test three different kinds of member at once: one member that is gated on and off alone, one channel that joins while a neighbour is enabled, and one channel that stays asynchronous. The prescaler width of 4 bits lets the bench write selects above 10, so the clamp at 2^10 can be observed. Its 2048-clock period still fits easily within the run.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int PSW     = 4;
  localparam int PRE_MAX = 10;

  function automatic logic [PSW-1:0] clamp_sel(input logic [PSW-1:0] s);
    return (s > PSW'(PRE_MAX)) ? PSW'(PRE_MAX) : s;
  endfunction
endpackage

// File: rtl/pwm_sync_ctrl.sv
module pwm_sync_ctrl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_wr,
  input  logic [NCH-1:0] sync_mask,
  input  logic [NCH-1:0] en_set,
  input  logic [NCH-1:0] en_clr,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] sync_q,
  output logic [NCH-1:0] grp
);
  logic [NCH-1:0] set_v, clr_v;

  always_comb begin
    grp    = sync_q;
    grp[0] = |sync_q;
    set_v  = en_set | (en_set[0] ? grp : '0);
    clr_v  = en_clr | (en_clr[0] ? grp : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sync_q <= '0;
    end else begin
      en_q <= (en_q | set_v) & ~clr_v;
      if (sync_wr)
        sync_q <= (sync_q & en_q) | (sync_mask & ~en_q);
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_sync_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [PSW-1:0] pre_sel,
  input  logic [CW-1:0]  period,
  input  logic           center,
  output logic [CW-1:0]  cnt
);
  logic [PRE_MAX-1:0] pre_cnt, lim;
  logic [PSW-1:0]     sel_c;
  logic               down, tick;

  always_comb begin
    sel_c = clamp_sel(pre_sel);
    lim   = ~({PRE_MAX{1'b1}} << sel_c);
    tick  = (pre_cnt == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
      down    <= 1'b0;
    end else if (!run) begin
      pre_cnt <= '0;
      cnt     <= '0;
      down    <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        if (!center) begin
          down <= 1'b0;
          cnt  <= (cnt >= period) ? '0 : cnt + 1'b1;
        end else if (period == '0) begin
          down <= 1'b0;
          cnt  <= '0;
        end else if (!down) begin
          if (cnt >= period) begin
            down <= 1'b1;
            cnt  <= period - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == '0) begin
          down <= 1'b0;
          cnt  <= CW'(1);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_sync_group.sv
module pwm_sync_group
  import pwm_sync_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_wr,
  input  logic [NCH-1:0]    sync_mask,
  input  logic [NCH-1:0]    en_set,
  input  logic [NCH-1:0]    en_clr,
  input  logic [NCH*PSW-1:0] cfg_pre,
  input  logic [NCH*CW-1:0] cfg_prd,
  input  logic [NCH-1:0]    cfg_center,
  input  logic [NCH*CW-1:0] cfg_duty,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    en_status,
  output logic [NCH-1:0]    sync_grp
);
  logic [NCH-1:0] en_q, sync_q, grp, run_v;
  logic [CW-1:0]  tb_cnt [NCH];
  logic [CW-1:0]  cnt0;

  pwm_sync_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_wr(sync_wr), .sync_mask(sync_mask),
    .en_set(en_set), .en_clr(en_clr), .en_q(en_q), .sync_q(sync_q), .grp(grp)
  );

  assign cnt0 = tb_cnt[0];

  // Channel 0 owns the shared timebase; members run on it, their own stays idle.
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt_sel;
    if (i == 0) begin : g_lead
      assign run_v[i] = en_q[0] | (|(en_q & grp));
      assign cnt_sel  = tb_cnt[0];
    end else begin : g_follow
      assign run_v[i] = en_q[i] & ~grp[i];
      assign cnt_sel  = grp[i] ? tb_cnt[0] : tb_cnt[i];
    end

    pwm_timebase #(.CW(CW)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run_v[i]),
      .pre_sel(cfg_pre[i*PSW +: PSW]), .period(cfg_prd[i*CW +: CW]),
      .center(cfg_center[i]), .cnt(tb_cnt[i])
    );

    assign pwm_out[i] = en_q[i] & (cnt_sel < cfg_duty[i*CW +: CW]);
  end

  assign en_status = en_q;
  assign sync_grp  = grp;
endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    en_set,
  input logic [NCH-1:0]    en_clr,
  input logic [NCH-1:0]    en_status,
  input logic [NCH-1:0]    sync_grp,
  input logic [NCH-1:0]    sync_q,
  input logic [NCH-1:0]    run_v,
  input logic [CW-1:0]     cnt0,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH*CW-1:0] cfg_duty
);
  // R5
  grp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set[0] && en_clr == '0) |=> ((en_status & $past(sync_grp)) == $past(sync_grp)));

  // R5
  grp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr[0] && sync_grp[0]) |=> ((en_status & $past(sync_grp)) == '0));

  // R7
  sync_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((sync_q ^ $past(sync_q)) & $past(en_status)) == '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_v[0] |=> (cnt0 == '0));

  for (genvar i = 1; i < NCH; i++) begin : g_lock
    // R1
    lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_status[0] && en_status[i] && sync_grp[i] &&
       cfg_duty[i*CW +: CW] == cfg_duty[CW-1:0]) |-> (pwm_out[i] == pwm_out[0]));
  end
endmodule

bind pwm_sync_group pwm_sync_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
  .en_status(en_status), .sync_grp(sync_grp), .sync_q(sync_q),
  .run_v(run_v), .cnt0(cnt0), .pwm_out(pwm_out), .cfg_duty(cfg_duty)
);

// File: tb/tb_pwm_sync_group.sv
`timescale 1ns/1ps
module tb_pwm_sync_group;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int PSW = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sync_wr = 1'b0;
  logic [NCH-1:0]    sync_mask = '0, en_set = '0, en_clr = '0;
  logic [NCH*PSW-1:0] cfg_pre = '0;
  logic [NCH*CW-1:0] cfg_prd = '0, cfg_duty = '0;
  logic [NCH-1:0]    cfg_center = '0;
  logic [NCH-1:0]    pwm_out, en_status, sync_grp;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwm_sync_group #(.NCH(NCH), .CW(CW)) dut (.*);

  typedef struct packed {
    logic        grp;
    logic [3:0]  pre0; logic [15:0] prd0; logic ctr0;
    logic [3:0]  pre1; logic [15:0] prd1; logic ctr1;
    logic [15:0] duty1; logic [15:0] win; logic [15:0] expv;
    logic [7:0]  req;
  } row_t;

  // channel 1 high count over a window of whole periods
  localparam row_t ROWS [8] = '{
    '{1'b0, 4'd0, 16'd9, 1'b0, 4'd0, 16'd9,   1'b0, 16'd3, 16'd40, 16'd12, 8'd8},  // R8
    '{1'b0, 4'd0, 16'd9, 1'b0, 4'd1, 16'd4,   1'b0, 16'd2, 16'd40, 16'd16, 8'd10}, // R10
    '{1'b0, 4'd0, 16'd9, 1'b0, 4'd0, 16'd5,   1'b1, 16'd3, 16'd40, 16'd20, 8'd9},  // R9
    '{1'b1, 4'd0, 16'd7, 1'b0, 4'd3, 16'd100, 1'b1, 16'd4, 16'd40, 16'd20, 8'd4},  // R4
    '{1'b1, 4'd1, 16'd3, 1'b1, 4'd0, 16'd9,   1'b0, 16'd2, 16'd48, 16'd24, 8'd4},  // R4
    '{1'b0, 4'd0, 16'd9, 1'b0, 4'd0, 16'd4,   1'b0, 16'd0, 16'd40, 16'd0,  8'd8},  // R8
    '{1'b0, 4'd0, 16'd9, 1'b0, 4'd0, 16'd4,   1'b0, 16'd9, 16'd40, 16'd40, 8'd8},  // R8
    '{1'b1, 4'd0, 16'd4, 1'b0, 4'd2, 16'd9,   1'b1, 16'd5, 16'd40, 16'd40, 8'd4}   // R4
  };

  task automatic check(input string tag, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic set_ch(input int i, input int pre, input int prd, input bit ctr, input int duty);
    cfg_pre[i*PSW +: PSW] = PSW'(pre);
    cfg_prd[i*CW +: CW]   = CW'(prd);
    cfg_center[i]         = ctr;
    cfg_duty[i*CW +: CW]  = CW'(duty);
  endtask

  task automatic strobe_en(input logic [NCH-1:0] s, input logic [NCH-1:0] c);
    en_set = s; en_clr = c;
    @(negedge clk);
    en_set = '0; en_clr = '0;
  endtask

  task automatic write_sync(input logic [NCH-1:0] m);
    sync_mask = m; sync_wr = 1'b1;
    @(negedge clk);
    sync_wr = 1'b0;
  endtask

  task automatic count_high(input int ch, input int win, output int hi);
    hi = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog got 0 expected 1 (run did not finish)");
      report();
    end
  end

  initial begin
    int hi, mis;
    repeat (3) @(negedge clk);
    // R12
    check("R12 pwm_out", int'(pwm_out), 0);
    check("R12 en_status", int'(en_status), 0);
    check("R12 sync_grp", int'(sync_grp), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 8; r++) begin
      strobe_en('0, '1);
      write_sync({2'b00, ROWS[r].grp, 1'b0});
      set_ch(0, ROWS[r].pre0, ROWS[r].prd0, ROWS[r].ctr0, 1);
      set_ch(1, ROWS[r].pre1, ROWS[r].prd1, ROWS[r].ctr1, ROWS[r].duty1);
      strobe_en(4'b0011, '0);
      repeat (30) @(negedge clk);
      count_high(1, ROWS[r].win, hi);
      check($sformatf("R%0d table row %0d", ROWS[r].req, r), hi, ROWS[r].expv);
    end

    // R2 R3: membership on channel 2 pulls in channel 0
    strobe_en('0, '1);
    write_sync(4'b0100);
    check("R3 sync_grp", int'(sync_grp), 5);
    // R11: everything disabled drives low
    check("R11 all off", int'(pwm_out), 0);

    // R5: enable through channel 0
    set_ch(0, 0, 7, 1'b0, 3);
    set_ch(2, 5, 2, 1'b1, 3);
    strobe_en(4'b0001, '0);
    check("R5 group start", int'(en_status), 5);

    // R1 R4: member follows channel 0 despite its own settings
    mis = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_out[2] != pwm_out[0]) mis++;
    end
    check("R1 R4 lockstep mismatches", mis, 0);
    count_high(0, 40, hi);
    check("R8 ch0 high count", hi, 15);

    // R6: member gated alone
    strobe_en('0, 4'b0100);
    check("R6 member off", int'(en_status), 1);
    count_high(2, 16, hi);
    check("R11 disabled member low", hi, 0);
    strobe_en(4'b0100, '0);
    check("R6 member on", int'(en_status), 5);
    mis = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_out[2] != pwm_out[0]) mis++;
    end
    check("R1 lockstep after rejoin", mis, 0);

    // R7: enabled channel 2 keeps its bit, disabled channel 1 takes its bit
    write_sync(4'b0000);
    check("R7 clear blocked", int'(sync_grp), 5);
    write_sync(4'b0010);
    check("R7 disabled takes bit", int'(sync_grp), 7);

    // R5: stop through channel 0
    strobe_en('0, 4'b0001);
    check("R5 group stop", int'(en_status), 0);
    check("R11 outputs low after stop", int'(pwm_out), 0);

    // R6: clear wins over group set on channel 2
    strobe_en(4'b0001, 4'b0100);
    check("R6 clear priority", int'(en_status), 3);

    // R10: select 15 acts as 10 on async channel 3
    set_ch(3, 15, 1, 1'b0, 1);
    strobe_en(4'b1000, '0);
    repeat (8) @(negedge clk);
    count_high(3, 4096, hi);
    check("R10 prescaler clamp", hi, 2048);

    finished = 1'b1;
    report();
  end
endmodule